// File: doc/BRIEF.md
# Row-Latched Nonvolatile Memory Write Controller

This block sits between a byte-wide processor bus and a small nonvolatile data array. It turns scattered byte writes into row-sized commit operations. A single control/status register has two live bits. The first is a write-mode enable. The second is a commit-start bit that also reads back as busy. While write mode is on, every bus write into the memory window lands in one of a bank of byte latches, chosen by the low address bits. The high address bits of the most recent such write name the target row. Setting the commit bit then runs a timed cycle that copies only the touched latches into that row of the array.

In read mode the array is read like plain ROM, and bus writes to the memory window are thrown away. In write mode, reads of the memory window leave the data bus undriven. Writing the same latch twice before the latches are cleared keeps the bitwise AND of both bytes. The latches are cleared when a commit cycle ends and when software drops write mode. A wait request is acknowledged only once no commit cycle is running. A halt request kills a running cycle in the same clock.

The array is a synchronous-read RAM outside the block. The controller drives its address, write strobe and write data, and returns its read data one clock after a bus read.

Top module: `eep_page_ctl`

## Requirements
- R1: After reset the control register reads 00h. On a register read the byte returned one clock later has bit 1 = write-mode enable, bit 0 = commit/busy, and bits 7:2 always 0.
- R2: With write mode off, a memory-window read returns the array byte at that address one clock later with `cpu_rdata_oe` high. A memory-window write in this mode changes nothing.
- R3: With write mode on, a memory-window write stores its byte in the latch selected by address bits 4:0. A memory-window read in this mode gives `cpu_rdata_oe` low in the following clock.
- R4: A register write with bit 0 set starts a commit cycle only if write mode was already on. With write mode off, bit 0 is ignored and `busy` stays low.
- R5: The commit cycle writes into the row given by address bits above bit 4 of the last latched write, whatever rows the earlier writes named.
- R6: Only latches written since the last clear are stored to the array; every other byte of the row keeps its value.
- R7: A second write to the same latch before a clear leaves the bitwise AND of the old and new bytes.
- R8: `busy` stays high for exactly PROG_CYCLES + 32 clocks. Its falling clock also clears write mode, so the register then reads 00h.
- R9: The latches are emptied at the end of a commit cycle and when software clears write mode, so no earlier byte is stored or ANDed afterwards.
- R10: While `busy` is high, register writes and memory-window writes are ignored. In particular, write mode cannot be cleared by software.
- R11: `wait_ack` is never high while `busy` is high. A wait request held across a commit cycle is acknowledged in the clock where `busy` falls.
- R12: A halt request during a commit cycle drops `busy` and write mode at the next edge and suppresses any further array write.
- R13: `arr_we` is high only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_csr_sel | input | 1 | 1 selects the control register, 0 the memory window |
| cpu_addr | input | ADDR_W | Byte address inside the memory window |
| cpu_wdata | input | DATA_W | Bus write data |
| cpu_wr | input | 1 | Bus write strobe, one clock per access |
| cpu_rd | input | 1 | Bus read strobe, one clock per access |
| cpu_rdata | output | DATA_W | Read data, valid in the clock after `cpu_rd` |
| cpu_rdata_oe | output | 1 | High when `cpu_rdata` is driven |
| wait_req | input | 1 | Request to enter wait state |
| halt_req | input | 1 | Request to halt; aborts a running cycle |
| wait_ack | output | 1 | Wait granted (no cycle running) |
| busy | output | 1 | Commit cycle in progress |
| arr_addr | output | ADDR_W | Array address |
| arr_wdata | output | DATA_W | Array write data |
| arr_we | output | 1 | Array write strobe |
| arr_re | output | 1 | Array read strobe |
| arr_rdata | input | DATA_W | Array read data, one clock after `arr_re` |

## Verification
The assertions assume that `cpu_rd` and `cpu_wr` are never high together, and that each strobe lasts exactly one clock. They also assume the array returns read data in the clock after `arr_re`. The stimulus keeps to these rules by driving every access at the falling edge and holding it for a single clock, with an idle clock between accesses. It also models the array as a synchronous-read RAM with one clock of latency. Halt requests are single-clock pulses sent only after a cycle has started. Wait requests are held as levels across cycle ends.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_TIMER  = 2'd1,
    SQ_COMMIT = 2'd2
  } sq_state_e;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_CSR  = 2'd1,
    RK_ARR  = 2'd2
  } rd_kind_e;

  localparam int unsigned CSR_PGM_BIT = 0;
  localparam int unsigned CSR_LAT_BIT = 1;
endpackage

// File: rtl/eep_csr.sv
module eep_csr
  import eep_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_csr,
  input  logic [1:0] wbits,
  input  logic       busy,
  input  logic       end_cycle,
  output logic       lat,
  output logic       start,
  output logic       lat_fall
);
  logic lat_q;
  logic wr_ok;

  assign wr_ok    = wr_csr && !busy;
  assign start    = wr_ok && lat_q && wbits[CSR_PGM_BIT];
  assign lat_fall = wr_ok && lat_q && !wbits[CSR_PGM_BIT] && !wbits[CSR_LAT_BIT];
  assign lat      = lat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q <= 1'b0;
    end else if (end_cycle) begin
      lat_q <= 1'b0;
    end else if (wr_ok && !start) begin
      lat_q <= wbits[CSR_LAT_BIT];
    end
  end
endmodule

// File: rtl/eep_latch_bank.sv
module eep_latch_bank #(
  parameter int unsigned NLAT   = 32,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(NLAT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld
);
  logic [NLAT-1:0][DATA_W-1:0] data_q;
  logic [NLAT-1:0]             vld_q;
  logic [NLAT-1:0]             slot_we;

  for (genvar g = 0; g < NLAT; g++) begin : g_slot
    assign slot_we[g] = wr_en && (wr_idx == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      data_q <= '0;
      vld_q  <= '0;
    end else begin
      for (int i = 0; i < NLAT; i++) begin
        if (slot_we[i]) begin
          data_q[i] <= vld_q[i] ? (data_q[i] & wr_data) : wr_data;
          vld_q[i]  <= 1'b1;
        end
      end
    end
  end

  assign rd_data = data_q[rd_idx];
  assign rd_vld  = vld_q[rd_idx];
endmodule

// File: rtl/eep_prog_seq.sv
module eep_prog_seq
  import eep_pkg::*;
#(
  parameter int unsigned NLAT        = 32,
  parameter int unsigned PROG_CYCLES = 64,
  localparam int unsigned IDX_W = $clog2(NLAT),
  localparam int unsigned TW    = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             halt,
  output logic             busy,
  output logic             busy_next,
  output logic             commit,
  output logic [IDX_W-1:0] idx,
  output logic             done,
  output logic             abort
);
  sq_state_e        state_q, state_d;
  logic [TW-1:0]    tmr_q;
  logic [IDX_W-1:0] idx_q;
  logic             tmr_last, idx_last;

  assign tmr_last = (tmr_q == TW'(PROG_CYCLES - 1));
  assign idx_last = (idx_q == IDX_W'(NLAT - 1));

  always_comb begin
    state_d = state_q;
    case (state_q)
      SQ_IDLE:   if (start && !halt) state_d = SQ_TIMER;
      SQ_TIMER:  if (halt) state_d = SQ_IDLE;
                 else if (tmr_last) state_d = SQ_COMMIT;
      SQ_COMMIT: if (halt || idx_last) state_d = SQ_IDLE;
      default:   state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      tmr_q   <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= (state_q == SQ_TIMER && state_d == SQ_TIMER) ? tmr_q + 1'b1 : '0;
      idx_q   <= (state_q == SQ_COMMIT && state_d == SQ_COMMIT) ? idx_q + 1'b1 : '0;
    end
  end

  assign busy      = (state_q != SQ_IDLE);
  assign busy_next = (state_d != SQ_IDLE);
  assign commit    = (state_q == SQ_COMMIT);
  assign idx       = idx_q;
  assign done      = commit && idx_last && !halt;
  assign abort     = busy && halt;
endmodule

// File: rtl/eep_page_ctl.sv
module eep_page_ctl
  import eep_pkg::*;
#(
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned NLAT        = 32,
  parameter int unsigned PROG_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_csr_sel,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rdata_oe,
  input  logic              wait_req,
  input  logic              halt_req,
  output logic              wait_ack,
  output logic              busy,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              arr_we,
  output logic              arr_re,
  input  logic [DATA_W-1:0] arr_rdata
);
  localparam int unsigned IDX_W = $clog2(NLAT);
  localparam int unsigned ROW_W = ADDR_W - IDX_W;

  logic              lat_q, start, lat_fall;
  logic              seq_busy, seq_busy_next, seq_commit, seq_done, seq_abort;
  logic [IDX_W-1:0]  seq_idx;
  logic              latch_we;
  logic [DATA_W-1:0] lb_data;
  logic              lb_vld;
  logic [ROW_W-1:0]  row_q;
  rd_kind_e          rk_q;
  logic [DATA_W-1:0] csr_q, csr_val;
  logic              wait_ack_q;

  eep_csr u_csr (
    .clk      (clk),
    .rst      (rst),
    .wr_csr   (cpu_wr && cpu_csr_sel),
    .wbits    (cpu_wdata[1:0]),
    .busy     (seq_busy),
    .end_cycle(seq_done || seq_abort),
    .lat      (lat_q),
    .start    (start),
    .lat_fall (lat_fall)
  );

  eep_prog_seq #(.NLAT(NLAT), .PROG_CYCLES(PROG_CYCLES)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .halt     (halt_req),
    .busy     (seq_busy),
    .busy_next(seq_busy_next),
    .commit   (seq_commit),
    .idx      (seq_idx),
    .done     (seq_done),
    .abort    (seq_abort)
  );

  assign latch_we = cpu_wr && !cpu_csr_sel && lat_q && !seq_busy;

  eep_latch_bank #(.NLAT(NLAT), .DATA_W(DATA_W)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .clr    (seq_done || seq_abort || lat_fall),
    .wr_en  (latch_we),
    .wr_idx (cpu_addr[IDX_W-1:0]),
    .wr_data(cpu_wdata),
    .rd_idx (seq_idx),
    .rd_data(lb_data),
    .rd_vld (lb_vld)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q <= '0;
    end else if (latch_we) begin
      row_q <= cpu_addr[ADDR_W-1:IDX_W];
    end
  end

  always_comb begin
    csr_val = '0;
    csr_val[CSR_LAT_BIT] = lat_q;
    csr_val[CSR_PGM_BIT] = seq_busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rk_q       <= RK_NONE;
      csr_q      <= '0;
      wait_ack_q <= 1'b0;
    end else begin
      rk_q <= RK_NONE;
      if (cpu_rd) begin
        if (cpu_csr_sel) begin
          rk_q  <= RK_CSR;
          csr_q <= csr_val;
        end else if (!lat_q) begin
          rk_q <= RK_ARR;
        end
      end
      wait_ack_q <= wait_req && !seq_busy_next;
    end
  end

  assign cpu_rdata_oe = (rk_q != RK_NONE);
  assign cpu_rdata    = (rk_q == RK_CSR) ? csr_q :
                        (rk_q == RK_ARR) ? arr_rdata : '0;

  assign arr_re    = cpu_rd && !cpu_csr_sel && !lat_q;
  assign arr_we    = seq_commit && lb_vld && !halt_req;
  assign arr_addr  = seq_commit ? {row_q, seq_idx} : cpu_addr;
  assign arr_wdata = lb_data;
  assign busy      = seq_busy;
  assign wait_ack  = wait_ack_q;
endmodule

// File: rtl/eep_page_ctl_chk.sv
module eep_page_ctl_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              lat,
  input logic              halt_req,
  input logic              cpu_rd,
  input logic              cpu_csr_sel,
  input logic              cpu_rdata_oe,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              arr_we,
  input logic              wait_ack,
  input logic              seq_done
);
  // R1
  csr_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_csr_sel) |=> (cpu_rdata_oe && cpu_rdata[DATA_W-1:2] == '0));

  // R3
  no_drive_wmode_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !cpu_csr_sel && lat) |=> !cpu_rdata_oe);

  // R10
  pgm_needs_lat_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> lat);

  // R8
  end_clears_both_chk: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> (!busy && !lat));

  // R11
  wait_vs_busy_chk: assert property (@(posedge clk) disable iff (rst)
    wait_ack |-> !busy);

  // R12
  halt_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (halt_req && busy) |=> (!busy && !lat));

  // R13
  we_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);
endmodule

bind eep_page_ctl eep_page_ctl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .busy        (busy),
  .lat         (lat_q),
  .halt_req    (halt_req),
  .cpu_rd      (cpu_rd),
  .cpu_csr_sel (cpu_csr_sel),
  .cpu_rdata_oe(cpu_rdata_oe),
  .cpu_rdata   (cpu_rdata),
  .arr_we      (arr_we),
  .wait_ack    (wait_ack),
  .seq_done    (seq_done)
);

// File: tb/eep_page_ctl_bench.sv
`timescale 1ns/100ps
module eep_page_ctl_bench;
  localparam int unsigned AW    = 8;
  localparam int unsigned DW    = 8;
  localparam int unsigned NL    = 32;
  localparam int unsigned PROG  = 20;
  localparam int unsigned DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_csr_sel = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_wr = 1'b0;
  logic          cpu_rd = 1'b0;
  logic [DW-1:0] cpu_rdata;
  logic          cpu_rdata_oe;
  logic          wait_req = 1'b0;
  logic          halt_req = 1'b0;
  logic          wait_ack, busy;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_wdata;
  logic          arr_we, arr_re;
  logic [DW-1:0] arr_rdata;

  int checks = 0;
  int fails  = 0;
  int busy_cnt = 0;
  int we_cnt   = 0;
  int stray    = 0;

  always #2.5 clk = ~clk;

  eep_page_ctl #(.ADDR_W(AW), .DATA_W(DW), .NLAT(NL), .PROG_CYCLES(PROG)) u_eep_page_ctl (
    .clk(clk), .rst(rst), .cpu_csr_sel(cpu_csr_sel), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
    .cpu_rdata_oe(cpu_rdata_oe), .wait_req(wait_req), .halt_req(halt_req),
    .wait_ack(wait_ack), .busy(busy), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .arr_we(arr_we), .arr_re(arr_re), .arr_rdata(arr_rdata)
  );

  function automatic logic [DW-1:0] init_val(input int a);
    return DW'(a) ^ 8'hA5;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= init_val(i);
      arr_rdata <= '0;
    end else begin
      if (arr_we) mem[arr_addr] <= arr_wdata;
      if (arr_re) arr_rdata <= mem[arr_addr];
    end
  end

  always @(posedge clk) begin
    if (!rst) begin
      if (busy) busy_cnt++;
      if (arr_we) begin
        if (busy) we_cnt++;
        else stray++;
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog actual=timeout expected=finished");
    summary();
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic sel, input int addr, input int data);
    @(negedge clk);
    cpu_csr_sel = sel; cpu_addr = AW'(addr); cpu_wdata = DW'(data); cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic sel, input int addr, output int data, output int oe);
    @(negedge clk);
    cpu_csr_sel = sel; cpu_addr = AW'(addr); cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
    data = int'(cpu_rdata);
    oe   = int'(cpu_rdata_oe);
  endtask

  task automatic mem_expect(input string req, input int addr, input int exp);
    int d, oe;
    bus_rd(1'b0, addr, d, oe);
    chk(req, oe, 1);
    chk(req, d, exp);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset();
    int d, oe;
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 oe after reset", int'(cpu_rdata_oe), 0);
    chk("R11 wait_ack after reset", int'(wait_ack), 0);
    bus_rd(1'b1, 0, d, oe);
    chk("R1 csr reset value", d, 'h00);
    chk("R1 csr read drives", oe, 1);
  endtask

  task automatic t_read_mode();
    mem_expect("R2 plain read", 'h23, init_val('h23));
    bus_wr(1'b0, 'h46, 'h00);
    mem_expect("R2 write in read mode discarded", 'h46, init_val('h46));
  endtask

  task automatic t_pgm_without_lat();
    int d, oe;
    bus_wr(1'b1, 0, 'h01);
    chk("R4 no start without write mode", int'(busy), 0);
    bus_rd(1'b1, 0, d, oe);
    chk("R4 csr after ignored start", d, 'h00);
  endtask

  task automatic t_program();
    int d, oe;
    bus_wr(1'b1, 0, 'h02);
    bus_rd(1'b1, 0, d, oe);
    chk("R1 csr write mode bit", d, 'h02);
    bus_wr(1'b0, 'h05, 'hF5);
    bus_wr(1'b0, 'h25, 'h5F);
    bus_wr(1'b0, 'h47, 'h3C);
    bus_rd(1'b0, 'h47, d, oe);
    chk("R3 read undriven in write mode", oe, 0);
    busy_cnt = 0; we_cnt = 0;
    bus_wr(1'b1, 0, 'h03);
    chk("R4 start with write mode", int'(busy), 1);
    bus_rd(1'b1, 0, d, oe);
    chk("R1 csr during cycle", d, 'h03);
    bus_wr(1'b1, 0, 'h00);
    bus_rd(1'b1, 0, d, oe);
    chk("R10 write mode kept during cycle", d, 'h03);
    bus_wr(1'b0, 'h48, 'h99);
    wait_req = 1'b1;
    @(negedge clk);
    chk("R11 no wait ack while busy", int'(wait_ack), 0);
    wait_idle();
    chk("R11 wait ack when busy falls", int'(wait_ack), 1);
    wait_req = 1'b0;
    chk("R8 busy length", busy_cnt, PROG + NL);
    bus_rd(1'b1, 0, d, oe);
    chk("R8 csr cleared at end", d, 'h00);
    chk("R6 array write count", we_cnt, 2);
    mem_expect("R7 AND of repeated latch", 'h45, 'h55);
    mem_expect("R5 row of last write", 'h47, 'h3C);
    mem_expect("R5 earlier row untouched", 'h05, init_val('h05));
    mem_expect("R5 middle row untouched", 'h25, init_val('h25));
    mem_expect("R6 unwritten byte kept", 'h46, init_val('h46));
    mem_expect("R10 write during cycle ignored", 'h48, init_val('h48));
  endtask

  task automatic t_lat_fall();
    bus_wr(1'b1, 0, 'h02);
    bus_wr(1'b0, 'h61, 'h11);
    bus_wr(1'b1, 0, 'h00);
    mem_expect("R9 dropped session not stored", 'h61, init_val('h61));
    bus_wr(1'b1, 0, 'h02);
    bus_wr(1'b0, 'h61, 'hEE);
    bus_wr(1'b1, 0, 'h03);
    wait_idle();
    mem_expect("R9 latch cleared by mode drop", 'h61, 'hEE);
    we_cnt = 0;
    bus_wr(1'b1, 0, 'h02);
    bus_wr(1'b0, 'h63, 'h33);
    bus_wr(1'b1, 0, 'h03);
    wait_idle();
    chk("R9 latches cleared after cycle", we_cnt, 1);
    mem_expect("R9 new byte stored", 'h63, 'h33);
  endtask

  task automatic t_halt();
    int d, oe;
    we_cnt = 0;
    bus_wr(1'b1, 0, 'h02);
    bus_wr(1'b0, 'h81, 'h77);
    bus_wr(1'b1, 0, 'h03);
    repeat (3) @(negedge clk);
    chk("R12 busy before halt", int'(busy), 1);
    halt_req = 1'b1;
    @(negedge clk);
    halt_req = 1'b0;
    chk("R12 busy dropped by halt", int'(busy), 0);
    bus_rd(1'b1, 0, d, oe);
    chk("R12 csr after halt", d, 'h00);
    chk("R12 no array write", we_cnt, 0);
    mem_expect("R12 array unchanged", 'h81, init_val('h81));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read_mode();
    t_pgm_without_lat();
    t_program();
    t_lat_fall();
    t_halt();
    chk("R13 no array write outside cycle", stray, 0);
    summary();
    $finish;
  end
endmodule